// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard-control logic for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. The pipeline has one memory that serves both instruction fetch and data access, and it resolves conditional branches in the decode stage. The block is purely combinational. It reads the register fields and control bits of the instructions held between the stages, plus the branch comparison made in decode. From these it drives the operand bypass selects for the execute stage, a hold on the program counter and the fetch/decode register, a no-op insert into the decode/execute register, a clear of the fetch/decode register, and the branch redirect of the program counter.

Results from the ALU reach a dependent instruction through the bypass network, so they cost no cycle. A load leaves its data only at the end of the memory stage, so a dependent instruction directly behind it waits one cycle and is then bypassed. When the memory stage reads or writes data, the shared memory cannot fetch. A taken branch loads its target from decode and replaces the wrongly fetched instruction with a no-op. The register file writes before it reads within a cycle, so a value being written back is already visible to decode.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An execute source register equal to the nonzero destination of a register-writing instruction in the memory stage selects the memory-stage bypass, select code 2'b10.
- R2: An execute source register equal to the nonzero destination of a register-writing instruction in write-back, with no memory-stage match, selects the write-back bypass, code 2'b01; with no match at all the select is 2'b00 (register file value).
- R3: When both the memory stage and write-back write the needed register, the select is 2'b10, the newer value.
- R4: Register 0 never produces a bypass, a load-use stall or a branch-operand stall.
- R5: A load in execute whose nonzero destination is a used decode source raises pc_hold, ifid_hold and idex_bubble, with no clear of the fetch/decode register.
- R6: A load or store in the memory stage, with no data stall and no taken branch, raises pc_hold and ifid_flush while ifid_hold and idex_bubble stay low.
- R7: When a data stall and a memory-stage access coincide, exactly one bubble results: pc_hold, ifid_hold and idex_bubble are high and ifid_flush is low.
- R8: A taken branch in decode with its operands ready raises pc_redirect and ifid_flush, with pc_hold low, also when the memory stage accesses data.
- R9: A branch that is not taken raises none of the control outputs on its own.
- R10: A branch in decode whose used source matches the nonzero destination of a register writer in execute or in the memory stage stalls as in R5, and pc_redirect stays low.
- R11: A decode source that matches only the write-back destination causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RAW | First source register of the decode-stage instruction |
| id_rs2 | input | RAW | Second source register of the decode-stage instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch comparison result from decode |
| ex_rs1 | input | RAW | First source register of the execute-stage instruction |
| ex_rs2 | input | RAW | Second source register of the execute-stage instruction |
| ex_rd | input | RAW | Destination register of the execute-stage instruction |
| ex_reg_wr | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RAW | Destination register of the memory-stage instruction |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| mem_is_store | input | 1 | Memory-stage instruction writes data memory |
| wb_rd | input | RAW | Destination register of the write-back instruction |
| wb_reg_wr | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Bypass select for the first execute operand |
| fwd_b | output | 2 | Bypass select for the second execute operand |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Load a no-op into the fetch/decode register |
| pc_redirect | output | 1 | Load the program counter with the branch target |

## Verification
Directed patterns separate the bypass cases (memory stage only, write-back only, both, register 0) so that a wrong priority or a missing zero check shows up as a wrong select code. Load-use, branch-operand and memory-access patterns are applied alone and in pairs, which tells a single-bubble merge apart from a double bubble or a lost fetch, and a taken branch under a memory access tells redirect priority apart from a plain hold. A long run of random stage contents drawn from only four register numbers makes matches frequent, and every cycle is compared with a behavioural model that scans the pipeline stages rather than mirroring the select logic.

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] id_rs1,
  input  logic [RAW-1:0] id_rs2,
  input  logic           id_use_rs1,
  input  logic           id_use_rs2,
  input  logic           id_is_branch,
  input  logic           id_br_taken,
  input  logic [RAW-1:0] ex_rs1,
  input  logic [RAW-1:0] ex_rs2,
  input  logic [RAW-1:0] ex_rd,
  input  logic           ex_reg_wr,
  input  logic           ex_is_load,
  input  logic [RAW-1:0] mem_rd,
  input  logic           mem_reg_wr,
  input  logic           mem_is_load,
  input  logic           mem_is_store,
  input  logic [RAW-1:0] wb_rd,
  input  logic           wb_reg_wr,
  output logic [1:0]     fwd_a,
  output logic [1:0]     fwd_b,
  output logic           pc_hold,
  output logic           ifid_hold,
  output logic           idex_bubble,
  output logic           ifid_flush,
  output logic           pc_redirect
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [RAW-1:0] R0  = '0;

  logic mem_live, wb_live, ex_live;
  assign mem_live = mem_reg_wr && (mem_rd != R0);
  assign wb_live  = wb_reg_wr  && (wb_rd  != R0);
  assign ex_live  = ex_reg_wr  && (ex_rd  != R0);

  logic mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;
  assign mem_hit_a = mem_live && (mem_rd == ex_rs1);
  assign mem_hit_b = mem_live && (mem_rd == ex_rs2);
  assign wb_hit_a  = wb_live  && (wb_rd  == ex_rs1);
  assign wb_hit_b  = wb_live  && (wb_rd  == ex_rs2);

  assign fwd_a = mem_hit_a ? SEL_MEM : (wb_hit_a ? SEL_WB : SEL_RF);
  assign fwd_b = mem_hit_b ? SEL_MEM : (wb_hit_b ? SEL_WB : SEL_RF);

  logic id_needs_ex, id_needs_mem;
  assign id_needs_ex  = ex_live  && ((id_use_rs1 && id_rs1 == ex_rd)  || (id_use_rs2 && id_rs2 == ex_rd));
  assign id_needs_mem = mem_live && ((id_use_rs1 && id_rs1 == mem_rd) || (id_use_rs2 && id_rs2 == mem_rd));

  logic load_use, br_wait, data_stall, mem_busy;
  assign load_use   = ex_is_load && id_needs_ex;
  assign br_wait    = id_is_branch && (id_needs_ex || id_needs_mem);
  assign data_stall = load_use || br_wait;
  assign mem_busy   = mem_is_load || mem_is_store;

  assign pc_redirect = id_is_branch && id_br_taken && !data_stall;
  assign pc_hold     = data_stall || (mem_busy && !pc_redirect);
  assign ifid_hold   = data_stall;
  assign idex_bubble = data_stall;
  assign ifid_flush  = !data_stall && (pc_redirect || mem_busy);

  always_comb begin
    if (!$isunknown({id_rs1, id_rs2, id_use_rs1, id_use_rs2, id_is_branch, id_br_taken,
                     ex_rs1, ex_rs2, ex_rd, ex_reg_wr, ex_is_load, mem_rd, mem_reg_wr,
                     mem_is_load, mem_is_store, wb_rd, wb_reg_wr})) begin
      a_r4_no_fwd_from_zero: assert ((ex_rs1 != R0 || fwd_a == SEL_RF) && (ex_rs2 != R0 || fwd_b == SEL_RF));
      a_r3_newest_wins: assert (!(mem_hit_a && wb_hit_a) || fwd_a == SEL_MEM);
      a_r5_stall_holds_all: assert (!idex_bubble || (pc_hold && ifid_hold));
      a_r7_single_bubble: assert (!(ifid_hold && ifid_flush));
      a_r8_redirect_moves_pc: assert (!pc_redirect || (ifid_flush && !pc_hold));
      a_r10_no_redirect_in_stall: assert (!(pc_redirect && idex_bubble));
      a_r6_no_fetch_on_access: assert (!mem_busy || pc_hold || pc_redirect);
    end
  end

endmodule

// File: tb/sim_pipe_hazard_unit.sv
`timescale 1ns/1ps
module sim_pipe_hazard_unit;
  localparam int RAW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [RAW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, id_is_branch, id_br_taken;
  logic ex_reg_wr, ex_is_load, mem_reg_wr, mem_is_load, mem_is_store, wb_reg_wr;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect;

  pipe_hazard_unit #(.RAW(RAW)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic clear_in();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    id_use_rs1 = 0; id_use_rs2 = 0; id_is_branch = 0; id_br_taken = 0;
    ex_reg_wr = 0; ex_is_load = 0; mem_reg_wr = 0; mem_is_load = 0; mem_is_store = 0; wb_reg_wr = 0;
  endtask

  // Behavioural model: scan older-to-newer producers, last writer wins.
  function automatic int model_sel(int src);
    int sel = 0;
    if (src == 0) return 0;
    if (wb_reg_wr && int'(wb_rd) == src) sel = 1;
    if (mem_reg_wr && int'(mem_rd) == src) sel = 2;
    return sel;
  endfunction

  function automatic bit reads(int r);
    if (r == 0) return 0;
    return (id_use_rs1 && int'(id_rs1) == r) || (id_use_rs2 && int'(id_rs2) == r);
  endfunction

  task automatic check1(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    bit stall, busy, redir;
    int e_hold, e_flush;
    stall = (ex_is_load && ex_reg_wr && reads(int'(ex_rd))) ||
            (id_is_branch && ((ex_reg_wr && reads(int'(ex_rd))) || (mem_reg_wr && reads(int'(mem_rd)))));
    busy  = mem_is_load || mem_is_store;
    redir = id_is_branch && id_br_taken && !stall;
    e_hold  = (stall || (busy && !redir)) ? 1 : 0;
    e_flush = (!stall && (busy || redir)) ? 1 : 0;
    check1(req, "fwd_a", int'(fwd_a), model_sel(int'(ex_rs1)));
    check1(req, "fwd_b", int'(fwd_b), model_sel(int'(ex_rs2)));
    check1(req, "pc_hold", int'(pc_hold), e_hold);
    check1(req, "ifid_hold", int'(ifid_hold), int'(stall));
    check1(req, "idex_bubble", int'(idex_bubble), int'(stall));
    check1(req, "ifid_flush", int'(ifid_flush), e_flush);
    check1(req, "pc_redirect", int'(pc_redirect), int'(redir));
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_ctl(string req, int h, int ih, int b, int f, int r);
    check1(req, "pc_hold", int'(pc_hold), h);
    check1(req, "ifid_hold", int'(ifid_hold), ih);
    check1(req, "idex_bubble", int'(idex_bubble), b);
    check1(req, "ifid_flush", int'(ifid_flush), f);
    check1(req, "pc_redirect", int'(pc_redirect), r);
  endtask

  initial begin
    clear_in();
    settle();
    // idle state
    check1("R2", "fwd_a idle", int'(fwd_a), 0);
    expect_ctl("R9", 0, 0, 0, 0, 0);

    // R1: memory-stage bypass
    @(negedge clk); clear_in(); ex_rs1 = 3; ex_rs2 = 4; mem_rd = 3; mem_reg_wr = 1; settle();
    check1("R1", "fwd_a", int'(fwd_a), 2); check1("R1", "fwd_b", int'(fwd_b), 0);
    expect_ctl("R1", 0, 0, 0, 0, 0);

    // R2: write-back bypass on second operand
    @(negedge clk); clear_in(); ex_rs1 = 6; ex_rs2 = 7; wb_rd = 7; wb_reg_wr = 1; settle();
    check1("R2", "fwd_b", int'(fwd_b), 1); check1("R2", "fwd_a", int'(fwd_a), 0);

    // R3: both match, newer wins
    @(negedge clk); clear_in(); ex_rs1 = 9; ex_rs2 = 9; mem_rd = 9; mem_reg_wr = 1; wb_rd = 9; wb_reg_wr = 1; settle();
    check1("R3", "fwd_a", int'(fwd_a), 2); check1("R3", "fwd_b", int'(fwd_b), 2);

    // R4: register 0 ignored everywhere
    @(negedge clk); clear_in(); ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_reg_wr = 1; wb_rd = 0; wb_reg_wr = 1;
    id_rs1 = 0; id_use_rs1 = 1; ex_rd = 0; ex_reg_wr = 1; ex_is_load = 1; settle();
    check1("R4", "fwd_a", int'(fwd_a), 0); check1("R4", "fwd_b", int'(fwd_b), 0);
    expect_ctl("R4", 0, 0, 0, 0, 0);
    @(negedge clk); id_is_branch = 1; settle();
    expect_ctl("R4", 0, 0, 0, 0, 0);

    // R5: load-use
    @(negedge clk); clear_in(); ex_rd = 5; ex_reg_wr = 1; ex_is_load = 1; id_rs2 = 5; id_use_rs2 = 1; settle();
    expect_ctl("R5", 1, 1, 1, 0, 0);
    @(negedge clk); id_use_rs2 = 0; settle();
    expect_ctl("R5", 0, 0, 0, 0, 0);
    @(negedge clk); id_use_rs2 = 1; ex_is_load = 0; settle();
    expect_ctl("R5", 0, 0, 0, 0, 0);

    // R6: shared-memory access
    @(negedge clk); clear_in(); mem_is_store = 1; settle();
    expect_ctl("R6", 1, 0, 0, 1, 0);
    @(negedge clk); mem_is_store = 0; mem_is_load = 1; mem_rd = 2; mem_reg_wr = 1; settle();
    expect_ctl("R6", 1, 0, 0, 1, 0);

    // R7: load-use and memory access together
    @(negedge clk); ex_rd = 8; ex_reg_wr = 1; ex_is_load = 1; id_rs1 = 8; id_use_rs1 = 1; settle();
    expect_ctl("R7", 1, 1, 1, 0, 0);

    // R8: taken branch, operands ready
    @(negedge clk); clear_in(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 1; id_use_rs1 = 1; settle();
    expect_ctl("R8", 0, 0, 0, 1, 1);
    @(negedge clk); mem_is_load = 1; mem_rd = 12; mem_reg_wr = 1; settle();
    expect_ctl("R8", 0, 0, 0, 1, 1);

    // R9: branch not taken
    @(negedge clk); clear_in(); id_is_branch = 1; id_rs1 = 1; id_use_rs1 = 1; settle();
    expect_ctl("R9", 0, 0, 0, 0, 0);

    // R10: branch operand produced in execute / memory stage
    @(negedge clk); clear_in(); id_is_branch = 1; id_br_taken = 1; id_rs2 = 11; id_use_rs2 = 1;
    ex_rd = 11; ex_reg_wr = 1; settle();
    expect_ctl("R10", 1, 1, 1, 0, 0);
    @(negedge clk); ex_reg_wr = 0; mem_rd = 11; mem_reg_wr = 1; settle();
    expect_ctl("R10", 1, 1, 1, 0, 0);

    // R11: write-back producer needs no stall
    @(negedge clk); mem_reg_wr = 0; wb_rd = 11; wb_reg_wr = 1; settle();
    expect_ctl("R11", 0, 0, 0, 1, 1);
    @(negedge clk); clear_in(); wb_rd = 13; wb_reg_wr = 1; id_rs1 = 13; id_use_rs1 = 1;
    ex_is_load = 1; settle();
    expect_ctl("R11", 0, 0, 0, 0, 0);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      id_rs1 = RAW'($urandom_range(0, 3)); id_rs2 = RAW'($urandom_range(0, 3));
      ex_rs1 = RAW'($urandom_range(0, 3)); ex_rs2 = RAW'($urandom_range(0, 3));
      ex_rd = RAW'($urandom_range(0, 3)); mem_rd = RAW'($urandom_range(0, 3)); wb_rd = RAW'($urandom_range(0, 3));
      id_use_rs1 = 1'($urandom); id_use_rs2 = 1'($urandom);
      id_is_branch = ($urandom_range(0, 3) == 0); id_br_taken = 1'($urandom);
      ex_reg_wr = 1'($urandom); ex_is_load = ex_reg_wr && ($urandom_range(0, 2) == 0);
      mem_reg_wr = 1'($urandom); mem_is_load = mem_reg_wr && ($urandom_range(0, 2) == 0);
      mem_is_store = !mem_reg_wr && ($urandom_range(0, 2) == 0);
      wb_reg_wr = 1'($urandom);
      settle();
      compare_all("R1/R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule